// File: doc/BRIEF.md
# Interrupt Enable Register Bank with Set/Clear Aliases

This block holds a small bank of interrupt enable registers behind a plain register bus. Two kinds of register share the bank. Enable-mask registers have one bit per interrupt source. Priority registers are split into multi-bit fields, one field per source. A dual-mode register has two addresses. Writing the first address sets bits and writing the second clears bits. A direct-mode priority register has one address, and a write stores the data as it is.

On each accepted write the block compares the new register value with the old one, one field at a time. It visits changed fields from the most significant down. For each changed field it reports one enable or disable event for the interrupt entry that the field maps to. An entry with no vector of its own is a group head. Its event is forwarded along a linked chain of member entries, one member per clock. While this walk runs, `busy` is high and further writes are dropped. Pending-interrupt logic that consumes the events lives outside this block.

Top module: `intc_mask_bank`

## Requirements
- R1: An address is decoded on its low 29 bits only, so 0xE4000004 reaches the same register as 0x04000004. Register r (0 and 1 are masks, 2 and 3 are priority) has its primary address at base + 8*r', where base is 0x04000000 for masks and 0x04000100 for priority registers, and r' is the index within its kind. A dual register also answers at primary + 4.
- R2: Both mask registers and priority register 2 are dual. A write to the primary address stores old | data, and a write to primary + 4 stores old & ~data. Only the low 8 data bits are used.
- R3: Priority register 3 is direct. A write to its primary address stores data[7:0], and its primary + 4 address is not mapped.
- R4: Either alias of a register reads back its stored value, zero-extended to 32 bits, starting in the cycle after the write. An unmapped address reads 0.
- R5: Mask register i bit b maps to entry ID 8*i + 7 - b. Priority register 2+j has 4-bit fields: bits [7:4] map to ID 16 + 2*j and bits [3:0] map to ID 17 + 2*j. Changed fields are handled from the most significant field down.
- R6: A field whose value did not change produces nothing. A changed field produces an event with `evt_enable` = 1 if its new value is nonzero and 0 if it is zero.
- R7: A field mapped to ID 0, or to an entry with neither a vector nor a link, produces no event. In the default tables the entries without a vector are 0, 5, 16-19, 21 and 27-31.
- R8: A field whose entry has a vector emits exactly one event carrying that entry's ID. That entry's link is not followed (default: 3 links to 26, and 26 is not reported).
- R9: A field whose entry has no vector but has a link forwards the same event along the chain, one member per cycle. Members with a vector emit the event, members without one are passed over, and the walk stops at a link of 0. Default chains: 16→20→21→22, 17→23 and 19→24→25.
- R10: `busy` is high from the cycle after an accepted write that changed at least one field until the walk has finished. A write that arrives while `busy` is high is dropped. A write that changes no field leaves `busy` low.
- R11: A write to an unmapped address changes no register and starts no walk.
- R12: After reset every register reads 0, `busy` is low and `evt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 32 | Bus address for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| busy | output | 1 | Event walk in progress; writes are dropped |
| evt_valid | output | 1 | An event is presented this cycle |
| evt_enable | output | 1 | 1 = enable event, 0 = disable event |
| evt_id | output | 5 | Entry ID the event applies to |

## Verification
A register value can be read combinationally in the cycle that follows the write edge. In that same cycle `busy` rises if any field changed, and the first step of the walk is shown. Each step, whether a field or a chain member, takes exactly one cycle, and its event is visible while `busy` is high. Steps that emit nothing still take their cycle. The bench therefore samples on falling edges from the first cycle after the write until `busy` falls, records each event in order, and compares the whole list and its length. Only after that does it read back the register.

// File: rtl/intc_bank_pkg.sv
// Package: shared types and default entry tables for the interrupt enable bank.
// Assumes entry IDs are 5 bits wide in the default tables.
package intc_bank_pkg;

    // Kind of access that a decoded address performs.
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_SET    = 2'd1,
        ACC_CLR    = 2'd2,
        ACC_DIRECT = 2'd3
    } acc_kind_e;

    localparam int ADDR_CMP_W  = 29;  // address bits taking part in decode
    localparam int REG_STRIDE  = 8;   // byte distance between registers
    localparam int CLR_OFS     = 4;   // offset of the clear alias
    localparam int DEF_ID_W    = 5;
    localparam int DEF_NUM_IDS = 1 << DEF_ID_W;

    // Which default entries carry a vector of their own.
    function automatic logic [DEF_NUM_IDS-1:0] default_vec_map();
        logic [DEF_NUM_IDS-1:0] v;
        v = '0;
        for (int i = 1; i <= 15; i++) v[i] = 1'b1;
        v[5]  = 1'b0;
        v[20] = 1'b1;
        for (int i = 22; i <= 26; i++) v[i] = 1'b1;
        return v;
    endfunction

    // Default chain links, ID_W bits per entry, 0 means end of chain.
    function automatic logic [DEF_NUM_IDS*DEF_ID_W-1:0] default_links();
        logic [DEF_NUM_IDS*DEF_ID_W-1:0] l;
        l = '0;
        l[3*DEF_ID_W  +: DEF_ID_W] = 5'd26;
        l[16*DEF_ID_W +: DEF_ID_W] = 5'd20;
        l[20*DEF_ID_W +: DEF_ID_W] = 5'd21;
        l[21*DEF_ID_W +: DEF_ID_W] = 5'd22;
        l[17*DEF_ID_W +: DEF_ID_W] = 5'd23;
        l[19*DEF_ID_W +: DEF_ID_W] = 5'd24;
        l[24*DEF_ID_W +: DEF_ID_W] = 5'd25;
        return l;
    endfunction

    localparam logic [DEF_NUM_IDS-1:0]          DEF_HAS_VEC = default_vec_map();
    localparam logic [DEF_NUM_IDS*DEF_ID_W-1:0] DEF_LINKS   = default_links();

    // True when register r owns a clear alias (all mask registers do).
    function automatic bit reg_is_dual(int r, int n_mask, logic [31:0] prio_dual);
        if (r < n_mask) return 1'b1;
        return prio_dual[r - n_mask];
    endfunction

endpackage

// File: rtl/intc_addr_dec.sv
// Address decoder: maps a bus address onto a register index and an access kind.
// Assumes registers sit REG_STRIDE bytes apart. Only the low ADDR_CMP_W bits decide.
module intc_addr_dec
    import intc_bank_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                N_MASK    = 2,
    parameter int                N_PRIO    = 2,
    parameter logic [N_PRIO-1:0] PRIO_DUAL = 2'b01,
    parameter logic [ADDR_W-1:0] MASK_BASE = 32'h0400_0000,
    parameter logic [ADDR_W-1:0] PRIO_BASE = 32'h0400_0100,
    parameter int                REG_IDX_W = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [REG_IDX_W-1:0] idx,
    output acc_kind_e            kind
);
    localparam int                N_REG    = N_MASK + N_PRIO;
    localparam logic [ADDR_W-1:0] CMP_MASK = ADDR_W'((64'd1 << ADDR_CMP_W) - 64'd1);

    logic [ADDR_W-1:0] a_m;
    logic [N_REG-1:0]  set_hit;
    logic [N_REG-1:0]  clr_hit;
    logic [N_REG-1:0]  dual_v;

    // Strip the address bits that do not take part in decode.
    assign a_m = addr & CMP_MASK;

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        localparam logic [ADDR_W-1:0] PRIM_A = (r < N_MASK)
            ? MASK_BASE + ADDR_W'(r * REG_STRIDE)
            : PRIO_BASE + ADDR_W'((r - N_MASK) * REG_STRIDE);
        localparam bit DUAL = reg_is_dual(r, N_MASK, 32'(PRIO_DUAL));
        // Match the primary address and, for dual registers, the clear alias.
        assign dual_v[r]  = DUAL;
        assign set_hit[r] = (a_m == (PRIM_A & CMP_MASK));
        assign clr_hit[r] = (DUAL != 1'b0) &&
                            (a_m == ((PRIM_A + ADDR_W'(CLR_OFS)) & CMP_MASK));
    end

    // Encode the matching register into an index and an access kind.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        kind = ACC_NONE;
        for (int r = 0; r < N_REG; r++) begin
            if (set_hit[r]) begin
                hit  = 1'b1;
                idx  = REG_IDX_W'(r);
                kind = dual_v[r] ? ACC_SET : ACC_DIRECT;
            end else if (clr_hit[r]) begin
                hit  = 1'b1;
                idx  = REG_IDX_W'(r);
                kind = ACC_CLR;
            end
        end
    end
endmodule

// File: rtl/intc_reg_store.sv
// Register storage: holds the bank and works out the value that a write produces.
// Assumes the caller raises wr_go only for a decoded write while the walker is idle.
module intc_reg_store
    import intc_bank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_W     = 8,
    parameter int N_REG     = 4,
    parameter int REG_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_go,
    input  logic                 hit,
    input  logic [REG_IDX_W-1:0] idx,
    input  acc_kind_e            kind,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 busy,
    output logic [DATA_W-1:0]    rd_data,
    output logic [REG_W-1:0]     old_val,
    output logic [REG_W-1:0]     new_val
);
    logic [N_REG-1:0][REG_W-1:0] regs;

    // Work out the value that the addressed register would take.
    always_comb begin
        old_val = regs[idx];
        unique case (kind)
            ACC_SET:    new_val = REG_W'(DATA_W'(old_val) | wr_data);
            ACC_CLR:    new_val = REG_W'(DATA_W'(old_val) & ~wr_data);
            ACC_DIRECT: new_val = REG_W'(wr_data);
            default:    new_val = old_val;
        endcase
    end

    // Store the new value on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) regs <= '0;
        else if (wr_go) regs[idx] <= new_val;
    end

    // Return the stored value for a mapped address, zero otherwise.
    assign rd_data = hit ? DATA_W'(old_val) : '0;

    AST_BUSY_HOLDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(regs)); // R10
    AST_SET_BITS_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && kind == ACC_SET) |=>
        ((regs[$past(idx)] & $past(wr_data[REG_W-1:0])) == $past(wr_data[REG_W-1:0]))); // R2
    AST_CLR_BITS_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && kind == ACC_CLR) |=>
        ((regs[$past(idx)] & $past(wr_data[REG_W-1:0])) == '0)); // R2
endmodule

// File: rtl/intc_evt_walker.sv
// Event walker: takes the field changes of one write and issues one step per cycle.
// A step is one changed field, taken from the most significant down, or one member
// of a group chain. Slot s of the field list maps to entry ID s.
// Assumes load is raised only while busy is low.
module intc_evt_walker #(
    parameter int REG_W     = 8,
    parameter int N_MASK    = 2,
    parameter int N_PRIO    = 2,
    parameter int PRIO_FW   = 4,
    parameter int REG_IDX_W = 2,
    parameter int ID_W      = 5,
    parameter logic [(1<<ID_W)-1:0]      HAS_VEC = '0,
    parameter logic [(1<<ID_W)*ID_W-1:0] LINKS   = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [REG_W-1:0]     old_val,
    input  logic [REG_W-1:0]     new_val,
    output logic                 busy,
    output logic                 evt_valid,
    output logic                 evt_enable,
    output logic [ID_W-1:0]      evt_id
);
    localparam int PRIO_NF = REG_W / PRIO_FW;
    localparam int N_SLOT  = N_MASK * REG_W + N_PRIO * PRIO_NF;
    localparam int SLOT_W  = $clog2(N_SLOT + 1);
    localparam int NF_W    = $clog2(REG_W + 1);
    localparam int FLD_W   = $clog2(REG_W);

    logic [REG_W-1:0]  chg_in, nz_in;
    logic              is_prio;
    logic [SLOT_W-1:0] base_in;
    logic [NF_W-1:0]   nf_in;

    logic [REG_W-1:0]  pend_q, nz_q;
    logic [SLOT_W-1:0] base_q;
    logic [NF_W-1:0]   nf_q;
    logic              chain_on_q, chain_en_q;
    logic [ID_W-1:0]   chain_id_q;

    logic [REG_W-1:0]  pend_n;
    logic              chain_on_n, chain_en_n;
    logic [ID_W-1:0]   chain_id_n;
    logic [FLD_W-1:0]  top_f;
    logic [ID_W-1:0]   field_id, link_of;

    // Find the changed fields of the write and whether each new value is nonzero.
    always_comb begin
        is_prio = int'(idx) >= N_MASK;
        chg_in  = '0;
        nz_in   = '0;
        if (!is_prio) begin
            chg_in = old_val ^ new_val;
            nz_in  = new_val;
        end else begin
            for (int f = 0; f < PRIO_NF; f++) begin
                chg_in[f] = old_val[f*PRIO_FW +: PRIO_FW] != new_val[f*PRIO_FW +: PRIO_FW];
                nz_in[f]  = |new_val[f*PRIO_FW +: PRIO_FW];
            end
        end
        base_in = is_prio ? SLOT_W'(N_MASK * REG_W + (int'(idx) - N_MASK) * PRIO_NF)
                          : SLOT_W'(int'(idx) * REG_W);
        nf_in   = is_prio ? NF_W'(PRIO_NF) : NF_W'(REG_W);
    end

    // Pick the most significant pending field and the ID it maps to.
    always_comb begin
        top_f = '0;
        for (int f = 0; f < REG_W; f++) begin
            if (pend_q[f]) top_f = FLD_W'(f);
        end
        field_id = ID_W'(base_q) + ID_W'(nf_q) - ID_W'(1) - ID_W'(top_f);
    end

    // Run one step: a chain member if a chain is open, otherwise the next field.
    always_comb begin
        pend_n     = pend_q;
        chain_on_n = chain_on_q;
        chain_id_n = chain_id_q;
        chain_en_n = chain_en_q;
        evt_valid  = 1'b0;
        evt_enable = 1'b0;
        evt_id     = '0;
        link_of    = '0;
        if (chain_on_q) begin
            link_of    = LINKS[chain_id_q*ID_W +: ID_W];
            evt_valid  = HAS_VEC[chain_id_q];
            evt_enable = chain_en_q;
            evt_id     = chain_id_q;
            if (link_of != '0) chain_id_n = link_of;
            else               chain_on_n = 1'b0;
        end else if (pend_q != '0) begin
            pend_n[top_f] = 1'b0;
            link_of       = LINKS[field_id*ID_W +: ID_W];
            if (field_id != '0) begin
                if (HAS_VEC[field_id]) begin
                    evt_valid  = 1'b1;
                    evt_enable = nz_q[top_f];
                    evt_id     = field_id;
                end else if (link_of != '0) begin
                    chain_on_n = 1'b1;
                    chain_id_n = link_of;
                    chain_en_n = nz_q[top_f];
                end
            end
        end
    end

    // Load a new walk or advance the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            nz_q       <= '0;
            base_q     <= '0;
            nf_q       <= '0;
            chain_on_q <= 1'b0;
            chain_en_q <= 1'b0;
            chain_id_q <= '0;
        end else if (load) begin
            pend_q     <= chg_in;
            nz_q       <= nz_in;
            base_q     <= base_in;
            nf_q       <= nf_in;
            chain_on_q <= 1'b0;
        end else begin
            pend_q     <= pend_n;
            chain_on_q <= chain_on_n;
            chain_id_q <= chain_id_n;
            chain_en_q <= chain_en_n;
        end
    end

    assign busy = (pend_q != '0) || chain_on_q;

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R10
    AST_FIELD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((pend_q & ~$past(pend_q)) == '0)); // R5
    AST_NO_ZERO_ID: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_id != '0)); // R7
    AST_EVT_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> busy); // R10
endmodule

// File: rtl/intc_mask_bank.sv
// Top: interrupt enable register bank with set/clear aliases and an event walker.
// A write is accepted only when it decodes to a register and no walk is running.
// Reads are combinational on addr.
module intc_mask_bank
    import intc_bank_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                REG_W     = 8,
    parameter int                N_MASK    = 2,
    parameter int                N_PRIO    = 2,
    parameter int                PRIO_FW   = 4,
    parameter logic [N_PRIO-1:0] PRIO_DUAL = 2'b01,
    parameter logic [ADDR_W-1:0] MASK_BASE = 32'h0400_0000,
    parameter logic [ADDR_W-1:0] PRIO_BASE = 32'h0400_0100,
    parameter int                ID_W      = DEF_ID_W,
    parameter logic [(1<<ID_W)-1:0]      HAS_VEC = DEF_HAS_VEC,
    parameter logic [(1<<ID_W)*ID_W-1:0] LINKS   = DEF_LINKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              evt_valid,
    output logic              evt_enable,
    output logic [ID_W-1:0]   evt_id
);
    localparam int N_REG     = N_MASK + N_PRIO;
    localparam int REG_IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;

    logic                 hit, wr_go;
    logic [REG_IDX_W-1:0] idx;
    acc_kind_e            kind;
    logic [REG_W-1:0]     old_val, new_val;

    // Accept a write only on a decoded address while no walk runs.
    assign wr_go = wr_en && hit && !busy;

    intc_addr_dec #(
        .ADDR_W(ADDR_W), .N_MASK(N_MASK), .N_PRIO(N_PRIO), .PRIO_DUAL(PRIO_DUAL),
        .MASK_BASE(MASK_BASE), .PRIO_BASE(PRIO_BASE), .REG_IDX_W(REG_IDX_W)
    ) u_dec (
        .addr(addr), .hit(hit), .idx(idx), .kind(kind)
    );

    intc_reg_store #(
        .DATA_W(DATA_W), .REG_W(REG_W), .N_REG(N_REG), .REG_IDX_W(REG_IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .hit(hit), .idx(idx), .kind(kind),
        .wr_data(wr_data), .busy(busy), .rd_data(rd_data),
        .old_val(old_val), .new_val(new_val)
    );

    intc_evt_walker #(
        .REG_W(REG_W), .N_MASK(N_MASK), .N_PRIO(N_PRIO), .PRIO_FW(PRIO_FW),
        .REG_IDX_W(REG_IDX_W), .ID_W(ID_W), .HAS_VEC(HAS_VEC), .LINKS(LINKS)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .load(wr_go), .idx(idx),
        .old_val(old_val), .new_val(new_val), .busy(busy),
        .evt_valid(evt_valid), .evt_enable(evt_enable), .evt_id(evt_id)
    );

    AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit && !busy) |=> !busy); // R11
endmodule

// File: tb/intc_mask_bank_test.sv
`timescale 1ns/1ps
module intc_mask_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy, evt_valid, evt_enable;
    logic [4:0]  evt_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [5:0] got [0:15];
    int got_n;

    always #5 clk = ~clk;

    intc_mask_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .evt_valid(evt_valid),
        .evt_enable(evt_enable), .evt_id(evt_id)
    );

    // Event code: {enable, id[4:0]}; the first event is in the low 6 bits.
    typedef struct packed {
        logic [31:0]     a;
        logic [31:0]     d;
        logic [31:0]     ra;
        logic [7:0]      rv;
        logic [3:0]      n;
        logic [5:0][5:0] ev;
    } vec_t;

    localparam vec_t VT [0:11] = '{
        '{32'h0400_0000, 32'hFF, 32'h0400_0004, 8'hFF, 4'd6, {6'h27,6'h26,6'h24,6'h23,6'h22,6'h21}},
        '{32'h0400_0004, 32'h0A, 32'h0400_0000, 8'hF5, 4'd2, {6'h0,6'h0,6'h0,6'h0,6'h06,6'h04}},
        '{32'h0400_0000, 32'h05, 32'h0400_0000, 8'hF5, 4'd0, {6'h0,6'h0,6'h0,6'h0,6'h0,6'h0}},
        '{32'h0400_0000, 32'h0A, 32'h0400_0004, 8'hFF, 4'd2, {6'h0,6'h0,6'h0,6'h0,6'h26,6'h24}},
        '{32'h0400_0100, 32'h10, 32'h0400_0104, 8'h10, 4'd2, {6'h0,6'h0,6'h0,6'h0,6'h36,6'h34}},
        '{32'h0400_0100, 32'h20, 32'h0400_0100, 8'h30, 4'd2, {6'h0,6'h0,6'h0,6'h0,6'h36,6'h34}},
        '{32'h0400_0104, 32'h30, 32'h0400_0100, 8'h00, 4'd2, {6'h0,6'h0,6'h0,6'h0,6'h16,6'h14}},
        '{32'h0400_0108, 32'h57, 32'h0400_0108, 8'h57, 4'd2, {6'h0,6'h0,6'h0,6'h0,6'h39,6'h38}},
        '{32'h0400_0108, 32'h50, 32'h0400_0108, 8'h50, 4'd2, {6'h0,6'h0,6'h0,6'h0,6'h19,6'h18}},
        '{32'h0400_0008, 32'h81, 32'h0400_000C, 8'h81, 4'd2, {6'h0,6'h0,6'h0,6'h0,6'h2F,6'h28}},
        '{32'h0400_0100, 32'h03, 32'h0400_0104, 8'h03, 4'd1, {6'h0,6'h0,6'h0,6'h0,6'h0,6'h37}},
        '{32'hE400_0004, 32'h40, 32'h0400_0000, 8'hBF, 4'd1, {6'h0,6'h0,6'h0,6'h0,6'h0,6'h01}}
    };

    function automatic string tag_of(int i);
        case (i)
            0:  return "R2 R5 R7 R8";
            1:  return "R2 R6";
            2:  return "R6 R10";
            3:  return "R2 R6";
            4:  return "R9";
            5:  return "R6 R9";
            6:  return "R2 R9";
            7:  return "R3 R7 R9";
            8:  return "R3 R6 R9";
            9:  return "R4 R5";
            10: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Record events from the cycle after the write until busy falls.
    task automatic collect();
        int guard = 0;
        got_n = 0;
        while (busy && guard < 100) begin
            if (evt_valid) begin
                if (got_n < 16) got[got_n] = {evt_enable, evt_id};
                got_n++;
            end
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic read_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(rd_data == exp, req, "readback", rd_data, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state.
        #1;
        check(busy == 1'b0, "R12", "busy after reset", 32'(busy), 0);
        check(evt_valid == 1'b0, "R12", "evt_valid after reset", 32'(evt_valid), 0);
        read_chk(32'h0400_0000, 0, "R12");
        read_chk(32'h0400_000C, 0, "R12");
        read_chk(32'h0400_0104, 0, "R12");
        read_chk(32'h0400_0108, 0, "R12");

        // Table of writes with the expected event list and readback.
        for (int i = 0; i < 12; i++) begin
            do_write(VT[i].a, VT[i].d);
            collect();
            check(got_n == int'(VT[i].n), tag_of(i), "event count", 32'(got_n), 32'(VT[i].n));
            for (int k = 0; k < int'(VT[i].n); k++) begin
                if (k < got_n)
                    check(got[k] == VT[i].ev[k], tag_of(i), "event", 32'(got[k]), 32'(VT[i].ev[k]));
            end
            read_chk(VT[i].ra, 32'(VT[i].rv), tag_of(i));
        end

        // R1: upper address bits ignored on read.
        read_chk(32'hE400_0000, 32'hBF, "R1");
        read_chk(32'h2400_0104, 32'h03, "R1");

        // R11 and R4: unmapped write and read, including the missing clear alias of the direct register.
        do_write(32'h0400_010C, 32'hFF);
        check(busy == 1'b0, "R11", "busy after unmapped write", 32'(busy), 0);
        read_chk(32'h0400_010C, 0, "R4");
        read_chk(32'h0400_0010, 0, "R4");
        read_chk(32'h0400_0108, 32'h50, "R11");

        // R10: a write arriving during a walk is dropped.
        do_write(32'h0400_000C, 32'hFF);
        check(busy == 1'b1, "R10", "busy in cycle after write", 32'(busy), 1);
        got_n = 0;
        if (evt_valid) begin got[got_n] = {evt_enable, evt_id}; got_n++; end
        addr = 32'h0400_0008; wr_data = 32'h7E; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        begin
            int guard = 0;
            while (busy && guard < 100) begin
                if (evt_valid) begin
                    if (got_n < 16) got[got_n] = {evt_enable, evt_id};
                    got_n++;
                end
                @(negedge clk);
                guard++;
            end
        end
        check(got_n == 2, "R10", "events during dropped write", 32'(got_n), 2);
        if (got_n >= 2) begin
            check(got[0] == 6'h08, "R10", "first event", 32'(got[0]), 32'h08);
            check(got[1] == 6'h0F, "R10", "second event", 32'(got[1]), 32'h0F);
        end
        read_chk(32'h0400_0008, 32'h00, "R10");

        // R12: reset again clears the bank.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_chk(32'h0400_0000, 0, "R12");
        read_chk(32'h0400_0108, 0, "R12");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule